// File: doc/BRIEF.md
# Two-Wire Transition-Signalled Serial Link

This block carries parallel words across a two-wire link where every bit is one level change on exactly one of the wires. The transmit side takes a word through a valid/ready handshake and shifts it out one bit per clock, most-significant bit first. The data wire always settles at the level of the bit being sent. When a bit repeats the level already on the data wire, the strobe wire toggles instead. Because of this, the XOR of the two wires flips once for every bit, and the receiver uses that flip to tell when a new bit has arrived.

The receive side registers the two wires and watches their parity. On every parity change it shifts in the data level. After a full word it presents the word with a one-cycle valid pulse and flips a single acknowledge line. That line crosses back to the transmit side through a two-flop synchronizer. The transmitter accepts no new word until it has seen that flip, so flow control costs one round trip per word rather than one per bit.

Top module: `ledr_link`

## Requirements
- R1: After reset `in_ready` is 1, `out_valid` is 0, and both link wires (`link_data`, `link_strobe`) are 0.
- R2: In any clock cycle at most one of the two link wires changes. Each accepted word causes exactly WIDTH wire changes.
- R3: After each bit's change, `link_data` equals the bit value. The strobe wire is the one that changes when the bit equals the previous `link_data` level; otherwise the data wire changes.
- R4: The bits of a word go out on consecutive cycles, starting with bit WIDTH-1 and ending with bit 0.
- R5: For each accepted word the receiver raises `out_valid` for exactly one cycle, with `out_data` equal to that word, and words are delivered in the order accepted.
- R6: One acknowledge toggle is returned per word. `in_ready` stays 0 from an accept until at least two cycles after that word's `out_valid` pulse.
- R7: A word is accepted only on a clock edge where both `in_valid` and `in_ready` are 1. Words presented while `in_ready` is 0 are never transmitted.
- R8: While no word is being shifted out, neither link wire changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both link ends |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | WIDTH | Word to send |
| in_valid | input | 1 | `in_data` is offered |
| in_ready | output | 1 | Transmitter can take a word |
| out_data | output | WIDTH | Received word |
| out_valid | output | 1 | One-cycle pulse per received word |
| link_data | output | 1 | Data wire of the link |
| link_strobe | output | 1 | Strobe wire of the link |

## Verification
Two events can fall in the same cycle. The first is the synchronized acknowledge releasing the transmitter. The second is a new word that is already waiting on `in_valid`. The bench provokes this by holding `in_valid` high through the whole wait, which makes the accept land on the first cycle `in_ready` returns. It then judges that the next word's first wire change follows the release and lands on neither wire of the previous word's tail. A separate decoder in the bench rebuilds every word from the raw wire changes. Words that keep the wires on the strobe-only path (all zeros straight after reset, all ones) are mixed with alternating patterns, and a scoreboard compares both the decoded wire stream and `out_data` against the accepted words.

// File: rtl/ledr_pkg.sv
package ledr_pkg;
  typedef enum logic [1:0] {
    TX_IDLE = 2'd0,
    TX_SEND = 2'd1,
    TX_WAIT = 2'd2
  } tx_state_t;
endpackage

// File: rtl/ledr_sync.sv
module ledr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= 1'b0;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/ledr_tx.sv
module ledr_tx
  import ledr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] in_data,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             ack_synced,
  output logic             wire_d,
  output logic             wire_s
);
  localparam int CW = $clog2(WIDTH + 1);

  tx_state_t        state;
  logic [WIDTH-1:0] shreg;
  logic [CW-1:0]    left;
  logic             ack_seen;
  logic             cur_bit;
  logic             take;

  assign cur_bit = shreg[WIDTH-1];
  assign take    = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= TX_IDLE;
      in_ready <= 1'b1;
      shreg    <= '0;
      left     <= '0;
      ack_seen <= 1'b0;
      wire_d   <= 1'b0;
      wire_s   <= 1'b0;
    end else begin
      case (state)
        TX_IDLE: begin
          if (take) begin
            shreg    <= in_data;
            left     <= CW'(WIDTH);
            state    <= TX_SEND;
            in_ready <= 1'b0;
          end
        end
        TX_SEND: begin
          if (cur_bit == wire_d) wire_s <= ~wire_s;
          else                   wire_d <= cur_bit;
          shreg <= shreg << 1;
          left  <= left - CW'(1);
          if (left == CW'(1)) state <= TX_WAIT;
        end
        TX_WAIT: begin
          if (ack_synced != ack_seen) begin
            ack_seen <= ack_synced;
            state    <= TX_IDLE;
            in_ready <= 1'b1;
          end
        end
        default: state <= TX_IDLE;
      endcase
    end
  end

  // R2: never both wires in one cycle
  p_one_wire_r2: assert property (@(posedge clk) disable iff (rst)
    !((wire_d != $past(wire_d)) && (wire_s != $past(wire_s))));

  // R8: quiet link when not shifting
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (state != TX_SEND) |=> ($stable(wire_d) && $stable(wire_s)));

  // R7: an accept drops ready on the next cycle
  p_accept_drop_r7: assert property (@(posedge clk) disable iff (rst)
    take |=> !in_ready);

  // R6: the transmitter stays parked until the synchronized toggle is seen
  p_wait_ack_r6: assert property (@(posedge clk) disable iff (rst)
    (state == TX_WAIT && ack_synced == ack_seen) |=> !in_ready);
endmodule

// File: rtl/ledr_rx.sv
module ledr_rx #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wire_d,
  input  logic             wire_s,
  output logic [WIDTH-1:0] out_data,
  output logic             out_valid,
  output logic             ack
);
  localparam int CW = $clog2(WIDTH);

  logic             d_q, s_q, par_q;
  logic [WIDTH-1:0] shreg;
  logic [CW-1:0]    got;
  logic             new_bit;
  logic [WIDTH-1:0] next_word;

  assign new_bit   = (d_q ^ s_q) != par_q;
  assign next_word = {shreg[WIDTH-2:0], d_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      d_q       <= 1'b0;
      s_q       <= 1'b0;
      par_q     <= 1'b0;
      shreg     <= '0;
      got       <= '0;
      out_data  <= '0;
      out_valid <= 1'b0;
      ack       <= 1'b0;
    end else begin
      d_q       <= wire_d;
      s_q       <= wire_s;
      out_valid <= 1'b0;
      if (new_bit) begin
        par_q <= d_q ^ s_q;
        shreg <= next_word;
        if (got == CW'(WIDTH - 1)) begin
          got       <= '0;
          out_data  <= next_word;
          out_valid <= 1'b1;
          ack       <= ~ack;
        end else begin
          got <= got + CW'(1);
        end
      end
    end
  end

  // R5: valid is a single-cycle pulse
  p_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  // R6: acknowledge flips only together with a delivered word
  p_ack_word_r6: assert property (@(posedge clk) disable iff (rst)
    (ack != $past(ack)) |-> out_valid);
endmodule

// File: rtl/ledr_link.sv
module ledr_link #(
  parameter int WIDTH      = 8,
  parameter int SYNC_DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] in_data,
  input  logic             in_valid,
  output logic             in_ready,
  output logic [WIDTH-1:0] out_data,
  output logic             out_valid,
  output logic             link_data,
  output logic             link_strobe
);
  logic rx_ack;
  logic ack_synced;

  ledr_tx #(.WIDTH(WIDTH)) u_tx (
    .clk        (clk),
    .rst        (rst),
    .in_data    (in_data),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .ack_synced (ack_synced),
    .wire_d     (link_data),
    .wire_s     (link_strobe)
  );

  ledr_rx #(.WIDTH(WIDTH)) u_rx (
    .clk       (clk),
    .rst       (rst),
    .wire_d    (link_data),
    .wire_s    (link_strobe),
    .out_data  (out_data),
    .out_valid (out_valid),
    .ack       (rx_ack)
  );

  ledr_sync #(.STAGES(SYNC_DEPTH)) u_ack_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (rx_ack),
    .dout (ack_synced)
  );
endmodule

// File: tb/ledr_link_test.sv
module ledr_link_test;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] in_data = '0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [W-1:0] out_data;
  logic         out_valid;
  logic         link_data, link_strobe;

  int tests = 0, fails = 0;
  int accepted = 0, wire_words = 0, delivered = 0;
  bit done = 0;
  logic [W-1:0] wire_q[$];
  logic [W-1:0] out_q[$];

  always #5 clk = ~clk;

  ledr_link #(.WIDTH(W)) uut (
    .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .out_data(out_data), .out_valid(out_valid),
    .link_data(link_data), .link_strobe(link_strobe)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // driver: holds valid until accepted, pushes expectations on accept (R7)
  task automatic send_word(input logic [W-1:0] w, input bit drop_after);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = w;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    wire_q.push_back(w);
    out_q.push_back(w);
    accepted++;
    if (drop_after) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // wire decoder and output monitor
  logic pd = 1'b0, ps = 1'b0, prev_rdy = 1'b1, prev_ov = 1'b0;
  logic [W-1:0] acc = '0;
  int nbits = 0, since_ov = 1000, gap = 0;

  always @(negedge clk) begin
    if (!rst && !done) begin
      if (link_data != pd && link_strobe != ps)
        check(0, "R2 both wires changed", {link_data, link_strobe}, {pd, ps});
      else if (link_data != pd || link_strobe != ps) begin
        if (accepted == wire_words)
          check(0, "R8 change with no word in flight", wire_words, accepted);
        if (nbits != 0) check(gap == 1, "R4 bits on consecutive cycles", gap, 1);
        acc = {acc[W-2:0], link_data};
        nbits++;
        gap = 0;
        if (nbits == W) begin
          logic [W-1:0] e;
          e = (wire_q.size() != 0) ? wire_q.pop_front() : 'x;
          check(acc === e, "R3/R4 word decoded from wires", acc, e);
          nbits = 0;
          wire_words++;
        end
      end
      gap++;
      pd = link_data;
      ps = link_strobe;

      if (out_valid) begin
        logic [W-1:0] e;
        check(!prev_ov, "R5 single-cycle valid", prev_ov, 0);
        e = (out_q.size() != 0) ? out_q.pop_front() : 'x;
        check(out_data === e, "R5 out_data", out_data, e);
        delivered++;
        since_ov = 0;
      end else since_ov++;
      prev_ov = out_valid;

      if (in_ready && !prev_rdy) begin
        check(delivered == accepted, "R6 ready before word acknowledged", delivered, accepted);
        check(since_ov >= 2, "R6 ack synchronizer delay", since_ov, 2);
      end
      prev_rdy = in_ready;
    end
  end

  // watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1;
      fails++; tests++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 100000);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] lfsr;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(in_ready == 1'b1, "R1 in_ready after reset", in_ready, 1);
    check(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
    check({link_data, link_strobe} == 2'b00, "R1 wires after reset", {link_data, link_strobe}, 0);

    send_word(8'h00, 1);
    send_word(8'hFF, 1);
    send_word(8'hA5, 0);   // valid held: back-to-back accept on release
    send_word(8'h5A, 0);
    send_word(8'h80, 0);
    send_word(8'h01, 1);

    // R7: junk offered while busy must not be transmitted
    send_word(8'h3C, 1);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = 8'hEE;
    repeat (3) @(negedge clk);
    check(in_ready == 1'b0, "R7 busy during junk offer", in_ready, 0);
    in_valid = 1'b0;

    lfsr = 8'hB7;
    for (int i = 0; i < 20; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      send_word(lfsr, (i % 3) == 0);
    end
    @(negedge clk);
    in_valid = 1'b0;

    while (delivered != accepted) @(negedge clk);
    repeat (20) @(negedge clk);
    check(delivered == 27, "R5 word count", delivered, 27);
    check(wire_words == 27, "R2 words on wire", wire_words, 27);
    check(in_ready == 1'b1, "R6 ready after final ack", in_ready, 1);
    check(wire_q.size() == 0 && out_q.size() == 0, "R5 scoreboard drained",
          wire_q.size() + out_q.size(), 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule